// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits between the command decoder and the column decoder of a synchronous DRAM. It turns each read or write column command into a per-clock stream of column addresses. A burst runs for 1, 2, 4 or 8 beats, or for a full page of 1024 columns. The beats follow either a sequential or an interleaved order inside an aligned block whose size is the burst length. A full-page burst keeps looping until it is stopped.

For reads, the block also delays a copy of each beat by the CAS latency (2 or 3 clocks). This produces the strobe and column tag that travel with read data on the output side. A write beat is driven in the same clock as the write command, because write data arrives together with the command.

The address stream is a valid-only stream (`col_valid` with `col_addr`) and has no ready signal. The memory array cannot stall, so the consumer must take a beat in every clock in which `col_valid` is high. For the same reason `cmd_rd`, `cmd_wr` and `cmd_stop` are accepted in every clock, so back-to-back column commands one clock apart are legal. The configuration inputs must stay stable while a burst or a read-data delay is in flight.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, and with no command, `col_valid`, `col_wr_en` and `rd_valid` are all low.
- R2: A column command produces its first beat in the same clock, with `col_addr` equal to `cmd_col`. `col_wr_en` is high on every beat of a write burst and low on every beat of a read burst.
- R3: In sequential order (`cfg_ilv`=0), beat k addresses the column whose low log2(L) bits are (start+k) mod L, where L is the burst length. The upper bits stay those of the start column.
- R4: In interleaved order (`cfg_ilv`=1, L of 2, 4 or 8), the low log2(L) bits of beat k are the start column's low bits XOR k. The upper bits stay those of the start column.
- R5: Length code `cfg_blen`=7 (bit 2 set) selects full page. Beats step sequentially whatever `cfg_ilv` is, wrap from 1023 to 0, return to the start column after 1024 beats, and continue until stopped.
- R6: Length codes 0, 1, 2 and 3 give bursts of exactly 1, 2, 4 and 8 beats. After the last beat, `col_valid` stays low until the next command.
- R7: `rd_valid` and `rd_col` repeat each read beat (`col_valid` high, `col_wr_en` low) and its address after 2 clocks when `cfg_cl3`=0, and after 3 clocks when `cfg_cl3`=1.
- R8: A new read or write during a burst ends the old burst at once and starts the new sequence in that clock. Read data already issued is still delivered on `rd_valid` up to the clock in which the new data begins.
- R9: A stop command produces no beat in its own clock and ends the burst. Read data already issued stays valid for CL-1 clocks after the stop clock, and `rd_valid` is low from CL clocks after it.
- R10: With `cfg_wr_single`=1, a write produces exactly one beat at `cmd_col`, while reads still burst at the configured length.
- R11: When several command inputs are high together, read takes priority over write, and write over stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_blen | input | 3 | Burst length code: 0/1/2/3 = 1/2/4/8 beats, bit 2 set = full page |
| cfg_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| cfg_cl3 | input | 1 | 1 = CAS latency 3, 0 = CAS latency 2 |
| cfg_wr_single | input | 1 | 1 = writes are single-beat |
| cmd_rd | input | 1 | Read column command |
| cmd_wr | input | 1 | Write column command |
| cmd_stop | input | 1 | Burst stop command |
| cmd_col | input | 10 | Start column of the command |
| col_valid | output | 1 | A beat is issued this clock |
| col_addr | output | 10 | Column address of the beat |
| col_wr_en | output | 1 | The beat is a write |
| rd_valid | output | 1 | Read data strobe, CAS latency after a read beat |
| rd_col | output | 10 | Column of the read data in this clock |

## Verification
The bench aims at wrap points: a start column in the middle of an 8-beat block, where a design that carries into the upper bits would leave the aligned block, and the 1023-to-0 step of a full page. It checks that interleaved order applies XOR rather than addition, and that full page ignores the order bit. It also checks the latency seam at an interruption or a stop, where a design that flushes its read delay line would drop the old burst's tail data. A design that kept issuing beats in the stop clock would write or read one column too many. A design that ignored single-write mode would write 8 columns where only one is meant to change.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  typedef enum logic [2:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE  = 3'd7
  } blen_e;

  // Bit 2 of the length code marks a full-page burst.
  function automatic logic is_page(logic [2:0] code);
    return code[2];
  endfunction

  // Wrap mask (length minus one) for the short burst lengths.
  function automatic logic [2:0] short_mask(logic [2:0] code);
    logic [2:0] m;
    case (code[1:0])
      2'd0:    m = 3'b000;
      2'd1:    m = 3'b001;
      2'd2:    m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bcg_addr_map.sv
module bcg_addr_map
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_col,
  input  logic [COL_W-1:0] beat,
  input  logic [2:0]       blen,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] low_part;

  always_comb begin
    wrap_mask = '0;
    if (is_page(blen)) wrap_mask = '1;
    else               wrap_mask[2:0] = short_mask(blen);
    // Full page always steps sequentially.
    if (ilv && !is_page(blen)) low_part = base_col ^ beat;
    else                       low_part = base_col + beat;
    addr = (base_col & ~wrap_mask) | (low_part & wrap_mask);
  end

endmodule

// File: rtl/bcg_sequencer.sv
module bcg_sequencer
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_blen,
  input  logic             cfg_ilv,
  input  logic             cfg_wr_single,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] cmd_col,
  output logic [COL_W-1:0] map_base,
  output logic [COL_W-1:0] map_beat,
  output logic [2:0]       map_blen,
  output logic             map_ilv,
  output logic             beat_v,
  output logic             beat_we
);

  logic             issue;
  logic             issue_wr;
  logic [2:0]       eff_blen;
  logic             last_beat;

  logic             st_act;
  logic             st_wr;
  logic             st_ilv;
  logic [2:0]       st_blen;
  logic [COL_W-1:0] st_base;
  logic [COL_W-1:0] st_beat;

  always_comb begin
    issue    = cmd_rd | cmd_wr;
    issue_wr = cmd_wr & ~cmd_rd;
    eff_blen = (issue_wr && cfg_wr_single) ? BL_ONE : cfg_blen;
    last_beat = !is_page(st_blen) &&
                (st_beat == {{(COL_W-3){1'b0}}, short_mask(st_blen)});
  end

  // A fresh command is presented to the mapper in its own clock.
  always_comb begin
    if (issue) begin
      map_base = cmd_col;
      map_beat = '0;
      map_blen = eff_blen;
      map_ilv  = cfg_ilv;
      beat_we  = issue_wr;
    end else begin
      map_base = st_base;
      map_beat = st_beat;
      map_blen = st_blen;
      map_ilv  = st_ilv;
      beat_we  = st_wr;
    end
    beat_v = issue | (st_act & ~cmd_stop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_act  <= 1'b0;
      st_wr   <= 1'b0;
      st_ilv  <= 1'b0;
      st_blen <= BL_ONE;
      st_base <= '0;
      st_beat <= '0;
    end else if (issue) begin
      st_act  <= (eff_blen != BL_ONE);
      st_wr   <= issue_wr;
      st_ilv  <= cfg_ilv;
      st_blen <= eff_blen;
      st_base <= cmd_col;
      st_beat <= {{(COL_W-1){1'b0}}, 1'b1};
    end else if (cmd_stop) begin
      st_act <= 1'b0;
    end else if (st_act) begin
      st_beat <= st_beat + 1'b1;
      if (last_beat) st_act <= 1'b0;
    end
  end

endmodule

// File: rtl/bcg_rd_pipe.sv
module bcg_rd_pipe #(
  parameter int COL_W  = 10,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_v,
  input  logic [COL_W-1:0] in_col,
  input  logic             sel_long,
  output logic             out_v,
  output logic [COL_W-1:0] out_col
);

  localparam int TAP_LONG  = MAX_CL - 1;
  localparam int TAP_SHORT = MAX_CL - 2;

  logic             v_q [MAX_CL];
  logic [COL_W-1:0] c_q [MAX_CL];

  for (genvar i = 0; i < MAX_CL; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0;
          c_q[0] <= '0;
        end else begin
          v_q[0] <= in_v;
          c_q[0] <= in_col;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q[i] <= 1'b0;
          c_q[i] <= '0;
        end else begin
          v_q[i] <= v_q[i-1];
          c_q[i] <= c_q[i-1];
        end
      end
    end
  end

  always_comb begin
    out_v   = sel_long ? v_q[TAP_LONG] : v_q[TAP_SHORT];
    out_col = sel_long ? c_q[TAP_LONG] : c_q[TAP_SHORT];
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg_blen,
  input  logic             cfg_ilv,
  input  logic             cfg_cl3,
  input  logic             cfg_wr_single,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_stop,
  input  logic [COL_W-1:0] cmd_col,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_wr_en,
  output logic             rd_valid,
  output logic [COL_W-1:0] rd_col
);

  logic [COL_W-1:0] map_base;
  logic [COL_W-1:0] map_beat;
  logic [2:0]       map_blen;
  logic             map_ilv;
  logic             beat_v;
  logic             beat_we;

  bcg_sequencer #(.COL_W(COL_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_blen      (cfg_blen),
    .cfg_ilv       (cfg_ilv),
    .cfg_wr_single (cfg_wr_single),
    .cmd_rd        (cmd_rd),
    .cmd_wr        (cmd_wr),
    .cmd_stop      (cmd_stop),
    .cmd_col       (cmd_col),
    .map_base      (map_base),
    .map_beat      (map_beat),
    .map_blen      (map_blen),
    .map_ilv       (map_ilv),
    .beat_v        (beat_v),
    .beat_we       (beat_we)
  );

  bcg_addr_map #(.COL_W(COL_W)) u_map (
    .base_col (map_base),
    .beat     (map_beat),
    .blen     (map_blen),
    .ilv      (map_ilv),
    .addr     (col_addr)
  );

  always_comb begin
    col_valid = beat_v;
    col_wr_en = beat_v & beat_we;
  end

  bcg_rd_pipe #(.COL_W(COL_W), .MAX_CL(MAX_CL)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_v     (beat_v & ~beat_we),
    .in_col   (col_addr),
    .sel_long (cfg_cl3),
    .out_v    (rd_valid),
    .out_col  (rd_col)
  );

endmodule

// File: rtl/bcg_checker.sv
module bcg_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_cl3,
  input logic             cfg_wr_single,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_stop,
  input logic [COL_W-1:0] cmd_col,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             col_wr_en,
  input logic             rd_valid
);

  logic [2:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n)         age <= '0;
    else if (age != 7)  age <= age + 1'b1;
  end

  AST_CMD_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rd || cmd_wr) |-> (col_valid && col_addr == cmd_col)); // R2

  AST_WR_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rd) |-> col_wr_en); // R2

  AST_RD_OVER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rd |-> !col_wr_en); // R11

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !cmd_rd && !cmd_wr) |-> !col_valid); // R9

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !cmd_rd && cfg_wr_single) |=> (col_valid |-> (cmd_rd || cmd_wr))); // R10

  AST_RD_LAT_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 4 && !cfg_cl3 && !$past(cfg_cl3, 1) && !$past(cfg_cl3, 2))
      |-> (rd_valid == $past(col_valid && !col_wr_en, 2))); // R7

  AST_RD_LAT_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 4 && cfg_cl3 && $past(cfg_cl3, 1) && $past(cfg_cl3, 2) && $past(cfg_cl3, 3))
      |-> (rd_valid == $past(col_valid && !col_wr_en, 3))); // R7

endmodule

bind burst_col_gen bcg_checker #(.COL_W(COL_W)) u_bcg_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_cl3       (cfg_cl3),
  .cfg_wr_single (cfg_wr_single),
  .cmd_rd        (cmd_rd),
  .cmd_wr        (cmd_wr),
  .cmd_stop      (cmd_stop),
  .cmd_col       (cmd_col),
  .col_valid     (col_valid),
  .col_addr      (col_addr),
  .col_wr_en     (col_wr_en),
  .rd_valid      (rd_valid)
);

// File: tb/burst_col_gen_test.sv
module burst_col_gen_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] cfg_blen;
  logic       cfg_ilv;
  logic       cfg_cl3;
  logic       cfg_wr_single;
  logic       cmd_rd;
  logic       cmd_wr;
  logic       cmd_stop;
  logic [9:0] cmd_col;
  logic       col_valid;
  logic [9:0] col_addr;
  logic       col_wr_en;
  logic       rd_valid;
  logic [9:0] rd_col;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int cl_now = 2;
  logic       hv [16];
  logic [9:0] ha [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_gen uut (
    .clk (clk), .rst_n (rst_n),
    .cfg_blen (cfg_blen), .cfg_ilv (cfg_ilv), .cfg_cl3 (cfg_cl3),
    .cfg_wr_single (cfg_wr_single),
    .cmd_rd (cmd_rd), .cmd_wr (cmd_wr), .cmd_stop (cmd_stop), .cmd_col (cmd_col),
    .col_valid (col_valid), .col_addr (col_addr), .col_wr_en (col_wr_en),
    .rd_valid (rd_valid), .rd_col (rd_col)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [9:0] exp_addr(input logic [9:0] s, input int k,
                                          input logic [2:0] bl, input logic il);
    logic [9:0] m;
    int len;
    len = bl[2] ? 1024 : (1 << bl[1:0]);
    m = 10'(len - 1);
    if (bl[2] || !il) return (s & ~m) | (10'(int'(s) + k) & m);
    return (s & ~m) | ((s ^ 10'(k)) & m);
  endfunction

  // One clock: drive at the falling edge, then check the beat and the delayed read data.
  task automatic step(input logic rd, input logic wr, input logic stp, input logic [9:0] col,
                      input logic ev, input logic [9:0] ea, input logic ewe, input string tag);
    logic exp_rv;
    logic [9:0] exp_rc;
    @(negedge clk);
    cmd_rd = rd; cmd_wr = wr; cmd_stop = stp; cmd_col = col;
    #1;
    chk(tag, "col_valid", col_valid, ev);
    if (ev) begin
      chk(tag, "col_addr", col_addr, ea);
      chk(tag, "col_wr_en", col_wr_en, ewe);
    end else begin
      chk(tag, "col_wr_en idle", col_wr_en, 1'b0);
    end
    exp_rv = 1'b0; exp_rc = '0;
    if (cyc >= cl_now) begin
      exp_rv = hv[(cyc - cl_now) % 16];
      exp_rc = ha[(cyc - cl_now) % 16];
    end
    chk("R7", "rd_valid", rd_valid, exp_rv);
    if (exp_rv) chk("R7", "rd_col", rd_col, exp_rc);
    hv[cyc % 16] = ev && !ewe;
    ha[cyc % 16] = ea;
    cyc++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, 0, '0, 0, tag);
  endtask

  task automatic run_burst(input logic is_wr, input logic [9:0] col, input int span, input string tag);
    int len;
    len = cfg_blen[2] ? 1024 : (1 << cfg_blen[1:0]);
    if (is_wr && cfg_wr_single) len = 1;
    for (int k = 0; k < span; k++)
      step(k == 0 && !is_wr, k == 0 && is_wr, 0, (k == 0) ? col : 10'd0,
           k < len, exp_addr(col, k, cfg_blen, cfg_ilv), is_wr, tag);
  endtask

  task automatic set_cl(input logic long_lat);
    idle(4, "R7");
    @(negedge clk);
    cfg_cl3 = long_lat;
    cl_now  = long_lat ? 3 : 2;
  endtask

  task automatic t_reset();
    idle(3, "R1");
  endtask

  task automatic t_sequential();
    set_cl(1'b0);
    cfg_blen = 3'd3; cfg_ilv = 1'b0;
    run_burst(1'b0, 10'h005, 12, "R3");
    cfg_blen = 3'd2;
    run_burst(1'b1, 10'h006, 7, "R6");
  endtask

  task automatic t_interleave();
    set_cl(1'b1);
    cfg_blen = 3'd3; cfg_ilv = 1'b1;
    run_burst(1'b0, 10'h105, 12, "R4");
    cfg_blen = 3'd2;
    run_burst(1'b0, 10'h0E2, 7, "R4");
  endtask

  task automatic t_short_writes();
    cfg_ilv = 1'b0;
    cfg_blen = 3'd1;
    run_burst(1'b1, 10'h00B, 4, "R2");
    cfg_blen = 3'd0;
    run_burst(1'b1, 10'h2A7, 3, "R6");
    run_burst(1'b0, 10'h2A8, 5, "R6");
  endtask

  task automatic t_page_stop();
    cfg_blen = 3'd7; cfg_ilv = 1'b1;
    for (int k = 0; k < 6; k++)
      step(k == 0, 0, 0, (k == 0) ? 10'h3FE : 10'd0, 1, exp_addr(10'h3FE, k, 3'd7, 1'b1), 0, "R5");
    step(0, 0, 1, '0, 0, '0, 0, "R9");
    idle(5, "R9");
  endtask

  task automatic t_page_wrap();
    cfg_blen = 3'd7; cfg_ilv = 1'b0;
    for (int k = 0; k < 1027; k++)
      step(0, k == 0, 0, (k == 0) ? 10'h3FE : 10'd0, 1, exp_addr(10'h3FE, k, 3'd7, 1'b0), 1, "R5");
    step(0, 0, 1, '0, 0, '0, 0, "R9");
    idle(3, "R9");
  endtask

  task automatic t_interrupt();
    cfg_blen = 3'd3; cfg_ilv = 1'b0;
    for (int k = 0; k < 3; k++)
      step(k == 0, 0, 0, (k == 0) ? 10'h010 : 10'd0, 1, exp_addr(10'h010, k, 3'd3, 1'b0), 0, "R8");
    for (int k = 0; k < 11; k++)
      step(k == 0, 0, 0, (k == 0) ? 10'h044 : 10'd0, k < 8, exp_addr(10'h044, k, 3'd3, 1'b0), 0, "R8");
    for (int k = 0; k < 2; k++)
      step(k == 0, 0, 0, (k == 0) ? 10'h020 : 10'd0, 1, exp_addr(10'h020, k, 3'd3, 1'b0), 0, "R8");
    for (int k = 0; k < 10; k++)
      step(0, k == 0, 0, (k == 0) ? 10'h033 : 10'd0, k < 8, exp_addr(10'h033, k, 3'd3, 1'b0), 1, "R8");
    idle(3, "R8");
  endtask

  task automatic t_single_write();
    cfg_blen = 3'd3; cfg_ilv = 1'b0; cfg_wr_single = 1'b1;
    run_burst(1'b1, 10'h012, 5, "R10");
    run_burst(1'b0, 10'h012, 10, "R10");
    cfg_wr_single = 1'b0;
  endtask

  task automatic t_priority();
    cfg_blen = 3'd0;
    step(1, 1, 1, 10'h050, 1, 10'h050, 0, "R11");
    step(0, 1, 1, 10'h051, 1, 10'h051, 1, "R11");
    idle(4, "R11");
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_blen = 3'd0; cfg_ilv = 1'b0; cfg_cl3 = 1'b0; cfg_wr_single = 1'b0;
    cmd_rd = 1'b0; cmd_wr = 1'b0; cmd_stop = 1'b0; cmd_col = '0;
    for (int i = 0; i < 16; i++) begin hv[i] = 1'b0; ha[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sequential();
    t_interleave();
    t_short_writes();
    t_page_stop();
    t_page_wrap();
    t_interrupt();
    t_single_write();
    t_priority();
    summary();
    $finish;
  end

endmodule